// File: doc/BRIEF.md
# Looping Playback Buffer

This block is a single-clock, dual-port sample store. It sits between a DMA engine that fills it and a converter that drains it. The write side stores words only while a transfer request is held high. Each new request starts filling again from address zero. A marker on the final word of a transfer records where that transfer ended. The read side does not track occupancy. While enabled, it walks the store without pause and replays the content as an endless loop.

Until a transfer has been marked complete, the loop covers the whole store. After the marker, the loop closes at the recorded address, so a short waveform repeats without stale tail content. A memory word is one lane per channel, with channel 0 in the least significant lane. A later request clears the recorded end point. Refilling then starts again from zero.

Top module: `playback_loop_buf`

## Requirements
- R1: A word is stored only in a cycle where `xfer_req` and `wr_valid` are both 1. In any other cycle the store and the write pointer stay unchanged.
- R2: Each stored word goes to the current write pointer, which then advances by one and wraps from 2^ADDR_WIDTH-1 to 0. Read activity never affects it.
- R3: In the cycle where `xfer_req` goes from 0 to 1, an accepted word is written at address 0. Without a word in that cycle, the write pointer becomes 0.
- R4: While no end marker is recorded, the read pointer steps 0, 1, …, 2^ADDR_WIDTH-1 and then returns to 0.
- R5: A `wr_last`=1 on an accepted word records that word's address as the end point. From the next cycle, the read pointer returns to 0 right after it reads that address. A pointer already past the end point first runs to the top of the store.
- R6: On a 0-to-1 edge of `xfer_req`, the recorded end point is dropped and full-depth looping resumes. The exception is a cycle that itself stores a word with `wr_last`=1, which records address 0.
- R7: While `rd_en` is 0, the next cycle shows `rd_data`=0 and `rd_valid`=0, and the read pointer returns to 0. The first enabled read therefore returns address 0.
- R8: `rd_data` is the word at the read pointer of the previous cycle, read before any same-cycle write. `rd_valid` equals `rd_en` delayed by one cycle.
- R9: Synchronous active-high `rst` clears the write pointer, the read pointer, the end point and its valid flag, `rd_data` and `rd_valid`.
- R10: A word is CH_CNT lanes of SAMPLE_W bits, with channel k in bits [k*SAMPLE_W +: SAMPLE_W]. Each lane is stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Transfer request; write window and restart on rising edge |
| wr_valid | input | 1 | Write word present |
| wr_last | input | 1 | Current word ends the transfer |
| wr_data | input | CH_CNT*SAMPLE_W | Packed samples, channel 0 lowest |
| rd_en | input | 1 | Read side enable |
| rd_data | output | CH_CNT*SAMPLE_W | Replayed word, 0 while disabled |
| rd_valid | output | 1 | `rd_data` carries a stored word |

## Verification
A full fill followed by a long read shows that the loop covers the whole store and wraps at the top. A short marked transfer shows that the loop closes at the recorded address. A later unmarked request shows that full-depth looping comes back. Writes attempted with the request low, and `rd_en` toggling in the middle of a loop, separate ignored stimulus from real updates and show the read restart at zero. A long seeded random mix of requests, markers, writes and enables, some of which collide with reads at the same address, is compared word by word with a bench model of both pointers.

// File: rtl/plb_pkg.sv
`timescale 1ns/1ps
package plb_pkg;

    localparam int DEF_ADDR_W   = 6;
    localparam int DEF_CH_CNT   = 2;
    localparam int DEF_SAMPLE_W = 16;

    typedef enum logic {
        WRAP_FULL = 1'b0,
        WRAP_LAST = 1'b1
    } wrap_mode_e;

    typedef struct packed {
        logic rise;    // request just went high
        logic accept;  // word stored this cycle
        logic mark;    // stored word closes the transfer
    } wr_evt_t;

    function automatic wr_evt_t decode_wr(input logic req, input logic req_q,
                                          input logic vld, input logic last);
        wr_evt_t e;
        e.rise   = req & ~req_q;
        e.accept = req & vld;
        e.mark   = req & vld & last;
        return e;
    endfunction

endpackage

// File: rtl/plb_wr_ctrl.sv
`timescale 1ns/1ps
module plb_wr_ctrl
    import plb_pkg::*;
#(
    parameter int AW = DEF_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_req,
    input  logic          wr_valid,
    input  logic          wr_last,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] last_addr,
    output wrap_mode_e    wrap_mode
);

    logic    req_q;
    wr_evt_t evt;

    always_comb begin
        evt       = decode_wr(xfer_req, req_q, wr_valid, wr_last);
        mem_we    = evt.accept;
        mem_waddr = evt.rise ? '0 : wr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            wr_ptr    <= '0;
            last_addr <= '0;
            wrap_mode <= WRAP_FULL;
        end else begin
            req_q <= xfer_req;
            if (evt.accept)
                wr_ptr <= mem_waddr + AW'(1);
            else if (evt.rise)
                wr_ptr <= '0;
            if (evt.mark) begin
                last_addr <= mem_waddr;
                wrap_mode <= WRAP_LAST;
            end else if (evt.rise) begin
                last_addr <= '0;
                wrap_mode <= WRAP_FULL;
            end
        end
    end

endmodule

// File: rtl/plb_rd_ctrl.sv
`timescale 1ns/1ps
module plb_rd_ctrl
    import plb_pkg::*;
#(
    parameter int AW = DEF_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  wrap_mode_e    wrap_mode,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] rd_addr
);

    logic [AW-1:0] limit;

    always_comb begin
        limit = (wrap_mode == WRAP_LAST) ? last_addr : {AW{1'b1}};
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en)
            rd_addr <= '0;
        else if (rd_addr == limit)
            rd_addr <= '0;
        else
            rd_addr <= rd_addr + AW'(1);
    end

endmodule

// File: rtl/plb_mem.sv
`timescale 1ns/1ps
module plb_mem
    import plb_pkg::*;
#(
    parameter int AW = DEF_ADDR_W,
    parameter int CH = DEF_CH_CNT,
    parameter int SW = DEF_SAMPLE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [CH*SW-1:0] wdata,
    input  logic            rd_en,
    input  logic [AW-1:0]   raddr,
    output logic [CH*SW-1:0] rdata,
    output logic            rvalid
);

    localparam int DEPTH = 1 << AW;

    for (genvar ch = 0; ch < CH; ch++) begin : g_lane
        logic [SW-1:0] lane [DEPTH];
        logic [SW-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (we)
                lane[waddr] <= wdata[ch*SW +: SW];
        end

        always_ff @(posedge clk) begin
            if (rst || !rd_en)
                lane_q <= '0;
            else
                lane_q <= lane[raddr];
        end

        assign rdata[ch*SW +: SW] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= rd_en;
    end

endmodule

// File: rtl/playback_loop_buf.sv
`timescale 1ns/1ps
module playback_loop_buf
    import plb_pkg::*;
#(
    parameter int ADDR_WIDTH = DEF_ADDR_W,
    parameter int CH_CNT     = DEF_CH_CNT,
    parameter int SAMPLE_W   = DEF_SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       xfer_req,
    input  logic                       wr_valid,
    input  logic                       wr_last,
    input  logic [CH_CNT*SAMPLE_W-1:0] wr_data,
    input  logic                       rd_en,
    output logic [CH_CNT*SAMPLE_W-1:0] rd_data,
    output logic                       rd_valid
);

    localparam int DATA_W = CH_CNT * SAMPLE_W;

    logic                  mem_we;
    logic [ADDR_WIDTH-1:0] mem_waddr;
    logic [ADDR_WIDTH-1:0] wr_ptr;
    logic [ADDR_WIDTH-1:0] last_addr;
    logic [ADDR_WIDTH-1:0] rd_addr;
    wrap_mode_e            wrap_mode;
    logic [DATA_W-1:0]     mem_rdata;

    plb_wr_ctrl #(.AW(ADDR_WIDTH)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .xfer_req  (xfer_req),
        .wr_valid  (wr_valid),
        .wr_last   (wr_last),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .wr_ptr    (wr_ptr),
        .last_addr (last_addr),
        .wrap_mode (wrap_mode)
    );

    plb_rd_ctrl #(.AW(ADDR_WIDTH)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .wrap_mode (wrap_mode),
        .last_addr (last_addr),
        .rd_addr   (rd_addr)
    );

    plb_mem #(.AW(ADDR_WIDTH), .CH(CH_CNT), .SW(SAMPLE_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .rd_en  (rd_en),
        .raddr  (rd_addr),
        .rdata  (mem_rdata),
        .rvalid (rd_valid)
    );

    assign rd_data = mem_rdata;

endmodule

// File: rtl/plb_chk.sv
`timescale 1ns/1ps
module plb_chk
    import plb_pkg::*;
#(
    parameter int AW = DEF_ADDR_W,
    parameter int DW = DEF_CH_CNT * DEF_SAMPLE_W
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_req,
    input logic          wr_valid,
    input logic          wr_last,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] last_addr,
    input logic [AW-1:0] rd_addr,
    input wrap_mode_e    wrap_mode
);

    // R1
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_req |=> $stable(wr_ptr));

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && $past(xfer_req) && wr_valid) |=> wr_ptr == AW'($past(wr_ptr) + AW'(1)));

    // R3
    wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !$past(xfer_req) && !wr_valid) |=> wr_ptr == '0);

    // R4
    rd_wrap_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wrap_mode == WRAP_FULL && rd_addr == {AW{1'b1}}) |=> rd_addr == '0);

    // R5
    rd_wrap_last_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wrap_mode == WRAP_LAST && rd_addr == last_addr) |=> rd_addr == '0);

    // R5
    mark_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && wr_valid && wr_last) |=> wrap_mode == WRAP_LAST);

    // R6
    mark_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !$past(xfer_req) && !(wr_valid && wr_last)) |=> wrap_mode == WRAP_FULL);

    // R7
    rd_off_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0 && !rd_valid && rd_addr == '0));

    // R8
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_ptr == '0 && rd_addr == '0 && last_addr == '0
                        && wrap_mode == WRAP_FULL && !rd_valid && rd_data == '0));

endmodule

bind playback_loop_buf plb_chk #(.AW(ADDR_WIDTH), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_req  (xfer_req),
    .wr_valid  (wr_valid),
    .wr_last   (wr_last),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wr_ptr    (wr_ptr),
    .last_addr (last_addr),
    .rd_addr   (rd_addr),
    .wrap_mode (wrap_mode)
);

// File: tb/playback_loop_buf_test.sv
`timescale 1ns/1ps
module playback_loop_buf_test;

    localparam int AW    = 6;
    localparam int CH    = 2;
    localparam int SW    = 16;
    localparam int DW    = CH * SW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_req = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_last = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R9";

    // bench model
    logic [DW-1:0] m_mem [DEPTH];
    int   m_wptr = 0;
    int   m_last = 0;
    bit   m_lvld = 1'b0;
    bit   m_req  = 1'b0;
    int   m_rp   = 0;

    always #2 clk = ~clk;  // 250 MHz

    playback_loop_buf #(.ADDR_WIDTH(AW), .CH_CNT(CH), .SAMPLE_W(SW)) uut (
        .clk      (clk),
        .rst      (rst),
        .xfer_req (xfer_req),
        .wr_valid (wr_valid),
        .wr_last  (wr_last),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] make_word(input int tag);
        logic [DW-1:0] w;
        for (int ch = 0; ch < CH; ch++)
            w[ch*SW +: SW] = SW'((ch + 1) * 16'h1000 + tag);
        return w;
    endfunction

    function automatic logic [DW-1:0] rand_word();
        logic [DW-1:0] w;
        for (int ch = 0; ch < CH; ch++)
            w[ch*SW +: SW] = SW'($urandom);
        return w;
    endfunction

    // one clock cycle: drive, model, compare both outputs
    task automatic step(input bit x, input bit wv, input bit wl,
                        input logic [DW-1:0] d, input bit re);
        bit rise;
        int eff;
        int lim;
        logic [DW-1:0] exp_d;
        @(negedge clk);
        xfer_req = x; wr_valid = wv; wr_last = wl; wr_data = d; rd_en = re;
        @(posedge clk);
        rise = x && !m_req;
        eff  = rise ? 0 : m_wptr;
        if (re) begin
            exp_d = m_mem[m_rp];
            lim   = m_lvld ? m_last : DEPTH - 1;
            m_rp  = (m_rp == lim) ? 0 : m_rp + 1;
        end else begin
            exp_d = '0;
            m_rp  = 0;
        end
        if (x && wv) begin
            m_mem[eff] = d;
            m_wptr = (eff + 1) % DEPTH;
        end else if (rise) begin
            m_wptr = 0;
        end
        if (x && wv && wl) begin
            m_last = eff;
            m_lvld = 1'b1;
        end else if (rise) begin
            m_last = 0;
            m_lvld = 1'b0;
        end
        m_req = x;
        #1;
        chk("rd_data", rd_data, exp_d);
        chk("rd_valid", DW'(rd_valid), DW'(re));
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state at the ports
        cur_req = "R9";
        chk("rd_data after reset", rd_data, '0);
        chk("rd_valid after reset", DW'(rd_valid), '0);

        // R10/R3/R2: fill the whole store from a fresh request
        cur_req = "R10";
        for (int i = 0; i < DEPTH; i++) step(1, 1, 0, make_word(i), 0);
        step(0, 0, 0, '0, 0);
        // R4: full-depth loop, more than one lap; R10 lanes come back intact
        cur_req = "R4";
        for (int i = 0; i < DEPTH + 20; i++) step(0, 0, 0, '0, 1);
        cur_req = "R10";
        step(0, 0, 0, '0, 0);
        step(0, 0, 0, '0, 1);
        chk("lane0 of word 0", DW'(rd_data[SW-1:0]), DW'(16'h1000));
        chk("lane1 of word 0", DW'(rd_data[2*SW-1:SW]), DW'(16'h2000));

        // R1: writes with request low are ignored, read content unchanged
        cur_req = "R1";
        step(0, 0, 0, '0, 0);
        for (int i = 0; i < 8; i++) step(0, 1, i[0], rand_word(), 0);
        for (int i = 0; i < 12; i++) step(0, 0, 0, '0, 1);

        // R3/R5: short marked transfer; loop closes at its last address
        cur_req = "R5";
        step(0, 0, 0, '0, 0);
        for (int i = 0; i < 10; i++) step(1, 1, (i == 9), make_word(100 + i), 0);
        step(1, 0, 0, '0, 0);
        for (int i = 0; i < 35; i++) step(1, 0, 0, '0, 1);

        // R6: new unmarked request restores full-depth loop
        cur_req = "R6";
        step(0, 0, 0, '0, 1);
        for (int i = 0; i < 3; i++) step(1, 1, 0, make_word(200 + i), 1);
        for (int i = 0; i < DEPTH + 8; i++) step(1, 0, 0, '0, 1);

        // R6 exception: marker on the rising-edge word records address 0
        step(0, 0, 0, '0, 0);
        step(1, 1, 1, make_word(300), 0);
        for (int i = 0; i < 6; i++) step(1, 0, 0, '0, 1);

        // R7: enable toggled mid-loop, restart at address 0
        cur_req = "R7";
        step(0, 0, 0, '0, 0);
        for (int i = 0; i < 20; i++) step(1, 1, (i == 15), make_word(400 + i), 0);
        for (int i = 0; i < 40; i++) step(0, 0, 0, '0, ((i % 7) != 3));

        // R2/R8: seeded random mix, including same-address read/write
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            bit x;
            x = (m_req ? (($urandom % 50) != 0) : (($urandom % 6) == 0));
            step(x, ($urandom % 3) != 0, ($urandom % 40) == 0, rand_word(),
                 ($urandom % 10) != 0);
        end
        cur_req = "R8";
        for (int i = 0; i < 30; i++) step(1, 1, 0, rand_word(), 1);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule